// File: doc/BRIEF.md
# Staged Clock Coefficient Register Block

This block holds the divider coefficients for four downstream clock domains (timer/PWM, independent watchdog, APB bus, IP core) and the PLL multiply/divide coefficients. Software writes new values into staged copies. The values reach the active outputs only when software sets the matching bit in the update register. Each update bit clears itself one cycle after it is written. A field can therefore be rewritten at any time without disturbing the clock it controls until the commit is issued.

The block also holds the system clock selection. This is the choice between the PLL clock and the source clock, plus the source choice between the internal RC oscillator and the external crystal. Selection writes take effect directly, and a reserved source encoding is dropped. From the active PLL coefficients the block derives the frequency ratio as a numerator/denominator pair. A flag warns software when the staged PLL divisor is zero, and a PLL commit is refused while that condition holds.

Register map (word address on `cfg_addr`):
- 0: clock selection. Bit 2 selects PLL (1) or source (0). Bits 1:0 select the source.
- 1: staged PLL fields.
- 2: staged dividers.
- 3: update bits.

Top module: `clkcfg_top`

## Requirements
- R1: After reset the readbacks are: selection 0x5 (PLL selected, source 01 = RC), PLL 0x1407, dividers 0x204080, update 0x0. Each active output equals the matching staged field. The ratio reads numerator 0x50, denominator 8, flag 0.
- R2: A write to address 2 (timer/PWM bits 23:17, watchdog 16:10, APB 9:6, IP core 5:0) or to address 1 (bypass bit 14, M 13:6, N 5:2, OD 1:0) changes the readback from the next cycle. The active outputs do not change.
- R3: Writing 1 to an update bit makes that bit read back 1 in the next cycle and 0 from the cycle after. In that later cycle the active field equals the staged value. The update bit positions are: 4 = timer/PWM, 3 = watchdog, 2 = APB, 1 = IP core, 0 = PLL.
- R4: A commit changes only the fields whose update bits were written as 1. All other active fields keep their values.
- R5: When the staged N is 0, `ratio_invalid` is 1 from the cycle after that write. A PLL commit then leaves the active PLL fields unchanged, and the update bit still clears.
- R6: A write to address 0 updates `sel_pll` from bit 2, and updates `sel_src` from bits 1:0 when they are 01 or 11. Both show in the next cycle.
- R7: A write to address 0 whose bits 1:0 are 00 or 10 leaves `sel_src` unchanged, while bit 2 still takes effect.
- R8: The ratio outputs give numerator M and denominator N·2^OD from the active PLL fields. When active bypass is 1, both are 1.
- R9: Write data bits beyond a register's fields are discarded and read back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register word address |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for `cfg_addr` (combinational) |
| sel_pll | output | 1 | 1 selects the PLL clock, 0 the source clock |
| sel_src | output | 2 | Source clock choice (01 RC, 11 crystal) |
| pll_bypass | output | 1 | Active PLL bypass |
| pll_m | output | 8 | Active PLL multiplier M |
| pll_n | output | 4 | Active PLL pre-divider N |
| pll_od | output | 2 | Active PLL output divider exponent OD |
| div_timer | output | 7 | Active timer/PWM divider |
| div_wdog | output | 7 | Active watchdog divider |
| div_apb | output | 4 | Active APB divider |
| div_ip | output | 6 | Active IP core divider |
| ratio_num | output | 8 | Frequency ratio numerator |
| ratio_den | output | 7 | Frequency ratio denominator |
| ratio_invalid | output | 1 | Staged PLL N is zero |

## Verification
Every result is checked at a fixed distance from the clock edge that samples the write:
- Staged readbacks, selection outputs, the invalid flag and the set update bit are due one cycle after that edge.
- Active coefficients, the ratio and the cleared update bit are due two cycles after it.

The driver records the cycle number when it issues each write and queues every expected value against its exact due cycle. The monitor compares at the falling edge of exactly that cycle and reports any item it reaches late. Each operation holds the address steady until all of its items are compared, so a readback never mixes two operations.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;
  localparam int REG_W  = 32;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    ADR_SEL = 2'd0,
    ADR_PLL = 2'd1,
    ADR_DIV = 2'd2,
    ADR_UPD = 2'd3
  } cfg_addr_e;

  // divider fields: index 0 IP core, 1 APB, 2 watchdog, 3 timer/PWM
  localparam int NUM_DIV = 4;
  localparam int DIV_W   [NUM_DIV] = '{6, 4, 7, 7};
  localparam int DIV_LSB [NUM_DIV] = '{0, 6, 10, 17};
  localparam int DIV_RST [NUM_DIV] = '{0, 2, 16, 16};
  localparam int DIV_SPAN = 24;

  // PLL fields
  localparam int OD_LSB  = 0;
  localparam int OD_W    = 2;
  localparam int N_LSB   = 2;
  localparam int N_W     = 4;
  localparam int M_LSB   = 6;
  localparam int M_W     = 8;
  localparam int BYP_BIT = 14;
  localparam int PLL_W   = BYP_BIT + 1;
  localparam logic [PLL_W-1:0] PLL_RST = 15'h1407;
  localparam int DEN_W   = N_W + (2**OD_W) - 1;

  // update bits: bit 0 PLL, bit g+1 divider g
  localparam int UPD_W   = NUM_DIV + 1;
  localparam int UPD_PLL = 0;

  // selection
  localparam logic [1:0] SRC_RC   = 2'b01;
  localparam logic [1:0] SRC_XTAL = 2'b11;
  localparam logic       SEL_PLL_RST = 1'b1;
  localparam logic [1:0] SEL_SRC_RST = SRC_RC;
endpackage

// File: rtl/clkcfg_rst_sync.sv
module clkcfg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_out = sync_q[STAGES-1];
endmodule

// File: rtl/clkcfg_stage_reg.sv
module clkcfg_stage_reg #(
  parameter int unsigned W = 8,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_val,
  input  logic         commit,
  output logic [W-1:0] staged,
  output logic [W-1:0] active
);
  logic [W-1:0] staged_q, staged_d;
  logic [W-1:0] active_q, active_d;

  always_comb begin
    staged_d = staged_q;
    active_d = active_q;
    if (wr_en)  staged_d = wr_val;
    if (commit) active_d = staged_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      staged_q <= RST_VAL;
      active_q <= RST_VAL;
    end else begin
      staged_q <= staged_d;
      active_q <= active_d;
    end
  end

  assign staged = staged_q;
  assign active = active_q;

  // R3: a commit copies the staged value seen at the commit edge
  a_r3_commit_copies: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (active == $past(staged)));

  // R2/R4: without a commit the active value holds
  a_r4_hold_without_commit: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(active));
endmodule

// File: rtl/clkcfg_update_ctrl.sv
module clkcfg_update_ctrl #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [N-1:0] wr_bits,
  input  logic [N-1:0] hold,
  output logic [N-1:0] pend,
  output logic [N-1:0] commit
);
  logic [N-1:0] pend_q, pend_d;

  always_comb begin
    pend_d = '0;
    if (wr_en) pend_d = wr_bits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  assign pend   = pend_q;
  assign commit = pend_q & ~hold;

  // R3: a pending bit never survives a cycle without a new write
  a_r3_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q != '0 && !wr_en) |=> (pend_q == '0));

  // R3: a written bit is pending in the next cycle
  a_r3_pend_set: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (pend_q == $past(wr_bits)));
endmodule

// File: rtl/clkcfg_pll_ratio.sv
module clkcfg_pll_ratio #(
  parameter int MW = 8,
  parameter int NW = 4,
  parameter int OW = 2,
  localparam int DW = NW + (2**OW) - 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bypass,
  input  logic [MW-1:0] m,
  input  logic [NW-1:0] n,
  input  logic [OW-1:0] od,
  output logic [MW-1:0] num,
  output logic [DW-1:0] den
);
  always_comb begin
    if (bypass) begin
      num = MW'(1);
      den = DW'(1);
    end else begin
      num = m;
      den = DW'(n) << od;
    end
  end

  // R8: denominator is never zero, since active N can never be zero
  a_r8_den_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    den != '0);
endmodule

// File: rtl/clkcfg_top.sv
module clkcfg_top
  import clkcfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [REG_W-1:0]  cfg_wdata,
  output logic [REG_W-1:0]  cfg_rdata,
  output logic              sel_pll,
  output logic [1:0]        sel_src,
  output logic              pll_bypass,
  output logic [M_W-1:0]    pll_m,
  output logic [N_W-1:0]    pll_n,
  output logic [OD_W-1:0]   pll_od,
  output logic [6:0]        div_timer,
  output logic [6:0]        div_wdog,
  output logic [3:0]        div_apb,
  output logic [5:0]        div_ip,
  output logic [M_W-1:0]    ratio_num,
  output logic [DEN_W-1:0]  ratio_den,
  output logic              ratio_invalid
);
  logic rst_n_s;
  logic sel_we, pll_we, div_we, upd_we;
  logic [UPD_W-1:0] upd_pend, upd_commit, upd_hold;
  logic [DIV_SPAN-1:0] div_staged, div_active;
  logic [PLL_W-1:0] pll_staged, pll_active;
  logic       pll_sel_q, pll_sel_d;
  logic [1:0] src_q, src_d;
  logic       src_ok;
  logic       staged_n_zero;
  logic       unused_wdata;

  assign unused_wdata = ^cfg_wdata[REG_W-1:DIV_SPAN];

  clkcfg_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk(clk), .rst_n_in(rst_n), .rst_n_out(rst_n_s)
  );

  // write decode
  always_comb begin
    sel_we = 1'b0;
    pll_we = 1'b0;
    div_we = 1'b0;
    upd_we = 1'b0;
    if (cfg_we) begin
      case (cfg_addr_e'(cfg_addr))
        ADR_SEL: sel_we = 1'b1;
        ADR_PLL: pll_we = 1'b1;
        ADR_DIV: div_we = 1'b1;
        ADR_UPD: upd_we = 1'b1;
        default: ;
      endcase
    end
  end

  // update controller; PLL commit held while staged N is zero
  assign staged_n_zero = (pll_staged[N_LSB +: N_W] == '0);
  always_comb begin
    upd_hold          = '0;
    upd_hold[UPD_PLL] = staged_n_zero;
  end

  clkcfg_update_ctrl #(.N(UPD_W)) u_upd (
    .clk(clk), .rst_n(rst_n_s), .wr_en(upd_we),
    .wr_bits(cfg_wdata[UPD_W-1:0]), .hold(upd_hold),
    .pend(upd_pend), .commit(upd_commit)
  );

  // divider fields
  for (genvar g = 0; g < NUM_DIV; g++) begin : g_div
    localparam int FW  = DIV_W[g];
    localparam int LSB = DIV_LSB[g];
    logic [FW-1:0] st, ac;
    clkcfg_stage_reg #(.W(FW), .RST_VAL(FW'(DIV_RST[g]))) u_field (
      .clk(clk), .rst_n(rst_n_s), .wr_en(div_we),
      .wr_val(cfg_wdata[LSB +: FW]), .commit(upd_commit[g+1]),
      .staged(st), .active(ac)
    );
    assign div_staged[LSB +: FW] = st;
    assign div_active[LSB +: FW] = ac;
  end

  // PLL fields
  clkcfg_stage_reg #(.W(PLL_W), .RST_VAL(PLL_RST)) u_pll (
    .clk(clk), .rst_n(rst_n_s), .wr_en(pll_we),
    .wr_val(cfg_wdata[PLL_W-1:0]), .commit(upd_commit[UPD_PLL]),
    .staged(pll_staged), .active(pll_active)
  );

  assign pll_bypass = pll_active[BYP_BIT];
  assign pll_m      = pll_active[M_LSB +: M_W];
  assign pll_n      = pll_active[N_LSB +: N_W];
  assign pll_od     = pll_active[OD_LSB +: OD_W];

  assign div_ip    = div_active[DIV_LSB[0] +: DIV_W[0]];
  assign div_apb   = div_active[DIV_LSB[1] +: DIV_W[1]];
  assign div_wdog  = div_active[DIV_LSB[2] +: DIV_W[2]];
  assign div_timer = div_active[DIV_LSB[3] +: DIV_W[3]];

  clkcfg_pll_ratio #(.MW(M_W), .NW(N_W), .OW(OD_W)) u_ratio (
    .clk(clk), .rst_n(rst_n_s), .bypass(pll_bypass),
    .m(pll_m), .n(pll_n), .od(pll_od),
    .num(ratio_num), .den(ratio_den)
  );
  assign ratio_invalid = staged_n_zero;

  // clock selection: direct effect, reserved source codes dropped
  assign src_ok = (cfg_wdata[1:0] == SRC_RC) || (cfg_wdata[1:0] == SRC_XTAL);

  always_comb begin
    pll_sel_d = pll_sel_q;
    src_d     = src_q;
    if (sel_we) begin
      pll_sel_d = cfg_wdata[2];
      if (src_ok) src_d = cfg_wdata[1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      pll_sel_q <= SEL_PLL_RST;
      src_q     <= SEL_SRC_RST;
    end else begin
      pll_sel_q <= pll_sel_d;
      src_q     <= src_d;
    end
  end

  assign sel_pll = pll_sel_q;
  assign sel_src = src_q;

  // readback
  always_comb begin
    case (cfg_addr_e'(cfg_addr))
      ADR_SEL: cfg_rdata = REG_W'({pll_sel_q, src_q});
      ADR_PLL: cfg_rdata = REG_W'(pll_staged);
      ADR_DIV: cfg_rdata = REG_W'(div_staged);
      ADR_UPD: cfg_rdata = REG_W'(upd_pend);
      default: cfg_rdata = '0;
    endcase
  end

  // R7: reserved source code leaves the source selection alone
  a_r7_reserved_src_ignored: assert property (@(posedge clk) disable iff (!rst_n_s)
    (sel_we && !src_ok) |=> $stable(sel_src));

  // R6: bit 2 of a selection write is taken
  a_r6_pll_sel_taken: assert property (@(posedge clk) disable iff (!rst_n_s)
    sel_we |=> (sel_pll == $past(cfg_wdata[2])));

  // R6: the source is always a legal encoding
  a_r6_src_legal: assert property (@(posedge clk) disable iff (!rst_n_s)
    (sel_src == SRC_RC) || (sel_src == SRC_XTAL));

  // R5: active N can never become zero
  a_r5_active_n_nonzero: assert property (@(posedge clk) disable iff (!rst_n_s)
    pll_n != '0);
endmodule

// File: tb/tb_clkcfg_top.sv
module tb_clkcfg_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  localparam int K_RD  = 0;
  localparam int K_DIV = 1;
  localparam int K_PLL = 2;
  localparam int K_SEL = 3;
  localparam int K_RAT = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_addr = 2'd0;
  logic [31:0] cfg_wdata = 32'd0;
  logic [31:0] cfg_rdata;
  logic        sel_pll;
  logic [1:0]  sel_src;
  logic        pll_bypass;
  logic [7:0]  pll_m;
  logic [3:0]  pll_n;
  logic [1:0]  pll_od;
  logic [6:0]  div_timer, div_wdog;
  logic [3:0]  div_apb;
  logic [5:0]  div_ip;
  logic [7:0]  ratio_num;
  logic [6:0]  ratio_den;
  logic        ratio_invalid;

  int cyc = 0;
  int errors = 0;
  int checks = 0;

  typedef struct {
    int          due;
    int          kind;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  clkcfg_top dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .sel_pll(sel_pll),
    .sel_src(sel_src), .pll_bypass(pll_bypass), .pll_m(pll_m),
    .pll_n(pll_n), .pll_od(pll_od), .div_timer(div_timer),
    .div_wdog(div_wdog), .div_apb(div_apb), .div_ip(div_ip),
    .ratio_num(ratio_num), .ratio_den(ratio_den), .ratio_invalid(ratio_invalid)
  );

  function automatic logic [31:0] div_pack(int t, int w, int a, int i);
    return (32'(t) << 17) | (32'(w) << 10) | (32'(a) << 6) | 32'(i);
  endfunction

  function automatic logic [31:0] pll_pack(int byp, int m, int n, int od);
    return (32'(byp) << 14) | (32'(m) << 6) | (32'(n) << 2) | 32'(od);
  endfunction

  function automatic logic [31:0] rat_pack(int inv, int num, int den);
    return (32'(inv) << 15) | (32'(num) << 7) | 32'(den);
  endfunction

  function automatic logic [31:0] actual(int kind);
    case (kind)
      K_RD:    return cfg_rdata;
      K_DIV:   return {8'h0, div_timer, div_wdog, div_apb, div_ip};
      K_PLL:   return {17'h0, pll_bypass, pll_m, pll_n, pll_od};
      K_SEL:   return {29'h0, sel_pll, sel_src};
      default: return {16'h0, ratio_invalid, ratio_num, ratio_den};
    endcase
  endfunction

  task automatic push(int due, int kind, logic [31:0] exp, string tag);
    item_t it;
    it.due = due; it.kind = kind; it.exp = exp; it.tag = tag;
    sb.push_back(it);
  endtask

  // monitor: compares each item in its due cycle
  initial begin
    forever begin
      @(negedge clk);
      while (sb.size() > 0 && sb[0].due <= cyc) begin
        item_t it;
        logic [31:0] act;
        it = sb.pop_front();
        act = actual(it.kind);
        checks++;
        if (it.due != cyc) begin
          errors++;
          $display("FAIL %s: item missed its cycle (due %0d, now %0d) actual=%h expected=%h",
                   it.tag, it.due, cyc, act, it.exp);
        end else if (act !== it.exp) begin
          errors++;
          $display("FAIL %s: kind=%0d actual=%h expected=%h", it.tag, it.kind, act, it.exp);
        end
      end
    end
  end

  task automatic issue(bit we, logic [1:0] a, logic [31:0] d, output int c);
    @(negedge clk);
    #1;
    cfg_we = we; cfg_addr = a; cfg_wdata = d;
    c = cyc;
  endtask

  task automatic settle(int c);
    @(negedge clk);
    #1;
    cfg_we = 1'b0;
    while (cyc < c + 3) @(negedge clk);
  endtask

  task automatic wr_chk(logic [1:0] a, logic [31:0] d, logic [31:0] rd1, logic [31:0] rd2,
                        int kind2, logic [31:0] exp2, string tag);
    int c;
    issue(1'b1, a, d, c);
    push(c + 1, K_RD, rd1, tag);
    push(c + 2, K_RD, rd2, tag);
    push(c + 2, kind2, exp2, tag);
    settle(c);
  endtask

  task automatic rd_chk(logic [1:0] a, logic [31:0] exp, string tag);
    int c;
    issue(1'b0, a, 32'd0, c);
    push(c + 1, K_RD, exp, tag);
    settle(c);
  endtask

  task automatic out_chk(int kind, logic [31:0] exp, string tag);
    int c;
    issue(1'b0, cfg_addr, 32'd0, c);
    push(c + 1, kind, exp, tag);
    settle(c);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int c;
    logic [31:0] div_new;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1 reset state
    rd_chk(2'd0, 32'h5, "R1 select readback");
    rd_chk(2'd1, 32'h1407, "R1 PLL readback");
    rd_chk(2'd2, 32'h204080, "R1 divider readback");
    rd_chk(2'd3, 32'h0, "R1 update readback");
    out_chk(K_DIV, div_pack(16, 16, 2, 0), "R1 active dividers");
    out_chk(K_PLL, pll_pack(0, 8'h50, 1, 3), "R1 active PLL");
    out_chk(K_SEL, 32'h5, "R1 selection outputs");
    out_chk(K_RAT, rat_pack(0, 8'h50, 8), "R1 ratio");

    // R2 and R9: staged divider write, upper bits dropped, active unchanged
    div_new = div_pack(8'h22, 8'h33, 9, 8'h15);
    issue(1'b1, 2'd2, div_new | 32'h8000_0000, c);
    push(c + 1, K_RD, div_new, "R9 upper bits dropped");
    push(c + 1, K_DIV, div_pack(16, 16, 2, 0), "R2 active held after staged write");
    push(c + 2, K_DIV, div_pack(16, 16, 2, 0), "R2 active still held");
    settle(c);

    // R3 and R4: commit APB only
    issue(1'b1, 2'd3, 32'h04, c);
    push(c + 1, K_RD, 32'h04, "R3 update bit reads 1");
    push(c + 1, K_DIV, div_pack(16, 16, 2, 0), "R3 no early commit");
    push(c + 2, K_RD, 32'h0, "R3 update bit self-clears");
    push(c + 2, K_DIV, div_pack(16, 16, 9, 0), "R4 only APB committed");
    settle(c);

    // R3: commit timer, watchdog, IP core together
    wr_chk(2'd3, 32'h1A, 32'h1A, 32'h0, K_DIV, div_new, "R3 multi-field commit");

    // R2: PLL staged write keeps active
    wr_chk(2'd1, pll_pack(0, 8'h20, 2, 1), pll_pack(0, 8'h20, 2, 1),
           pll_pack(0, 8'h20, 2, 1), K_PLL, pll_pack(0, 8'h50, 1, 3), "R2 PLL staged only");
    // R3/R8: PLL commit and ratio
    wr_chk(2'd3, 32'h01, 32'h01, 32'h0, K_PLL, pll_pack(0, 8'h20, 2, 1), "R3 PLL commit");
    out_chk(K_RAT, rat_pack(0, 8'h20, 4), "R8 ratio M over N*2^OD");

    // R5: N = 0 raises flag and blocks commit
    issue(1'b1, 2'd1, pll_pack(0, 8'h40, 0, 0), c);
    push(c + 1, K_RAT, rat_pack(1, 8'h20, 4), "R5 invalid flag set");
    settle(c);
    wr_chk(2'd3, 32'h01, 32'h01, 32'h0, K_PLL, pll_pack(0, 8'h20, 2, 1), "R5 PLL commit blocked");
    out_chk(K_DIV, div_new, "R4 dividers untouched by PLL commit");

    // R8: bypass gives unity ratio
    wr_chk(2'd1, pll_pack(1, 8'h10, 3, 2), pll_pack(1, 8'h10, 3, 2),
           pll_pack(1, 8'h10, 3, 2), K_RAT, rat_pack(0, 8'h20, 4), "R5 flag clears");
    wr_chk(2'd3, 32'h01, 32'h01, 32'h0, K_RAT, rat_pack(0, 1, 1), "R8 bypass unity ratio");
    out_chk(K_PLL, pll_pack(1, 8'h10, 3, 2), "R3 bypass PLL committed");

    // R6 and R7: selection
    issue(1'b1, 2'd0, 32'h3, c);
    push(c + 1, K_SEL, 32'h3, "R6 source crystal, PLL off");
    settle(c);
    issue(1'b1, 2'd0, 32'h4, c);
    push(c + 1, K_SEL, 32'h7, "R7 reserved 00 ignored, bit 2 taken");
    settle(c);
    issue(1'b1, 2'd0, 32'h2, c);
    push(c + 1, K_SEL, 32'h3, "R7 reserved 10 ignored");
    settle(c);
    issue(1'b1, 2'd0, 32'hFFFF_FFF1, c);
    push(c + 1, K_SEL, 32'h1, "R6 source RC");
    push(c + 1, K_RD, 32'h1, "R9 select upper bits dropped");
    settle(c);

    while (sb.size() > 0) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule